// File: doc/BRIEF.md
# Sector Hamming Check-Code Comparator

This block decides what went wrong with a 512-byte sector after it is read back from flash. It takes two 3-byte Hamming check codes in one strobe: the code kept in the spare area and the code computed while the data streamed in. It reorders the nibbles of both codes into a 32-bit layout and XORs them. It then sorts the sector into one of four outcomes by the number of set bits in that difference. The four outcomes are: nothing wrong, one data bit flipped, the stored code itself damaged, or damage beyond repair.

For a single flipped data bit the block reports which byte of the sector holds it and which bit within that byte. When built with correction enabled, it also repairs the bit itself. It does this with one read-modify-write on an attached byte-wide sector buffer that has a one-cycle read latency. A freshly erased sector reads back as all ones with a computed code of zero, and the block reports it as clean instead of uncorrectable.

Producing the Hamming code from the data stream is done elsewhere.

Top module: `ecc_sector_checker`

## Requirements
- R1: Each 24-bit code (byte0 = bits 7:0, byte1 = bits 15:8, byte2 = bits 23:16) is reordered into a 32-bit word. Byte0 goes to word bits 7:0, byte1 to bits 23:16, the low nibble of byte2 to bits 11:8, and the high nibble of byte2 to bits 27:24. All other word bits are zero.
- R2: When the two reordered words XOR to zero, the status is 0 (clean).
- R3: When the XOR has exactly 12 set bits, the status is 1 (corrected). The bit index is XOR bits 18:16 and the byte index is XOR bits 27:19.
- R4: When the XOR has exactly one set bit, the status is 2 (check code corrupt), and the sector buffer is neither read nor written.
- R5: A stored code that reorders to 0x0FFF0FFF together with a computed code of zero gives status 0 (erased sector).
- R6: Every other nonzero XOR gives status 3 (uncorrectable).
- R7: The result is flagged by `done`, which is a single-cycle pulse. It is high in the second clock cycle after the cycle in which `code_valid` is sampled.
- R8: The byte and bit indices read zero whenever the status is not 1.
- R9: With correction enabled, each corrected result starts a read-modify-write. `fix_rd_en` pulses one cycle after `done`. `fix_wr_en` pulses two cycles after that, at the same address, with the read byte XOR a one-hot mask at the reported bit.
- R10: After synchronous reset, `done`, `status`, `fix_rd_en` and `fix_wr_en` are all zero.
- R11: Strobes on consecutive cycles each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_valid | input | 1 | Strobe: both codes are valid this cycle |
| stored_code | input | 24 | Check code read from the spare area |
| calc_code | input | 24 | Check code computed over the data read |
| done | output | 1 | Result valid pulse |
| status | output | 2 | 0 clean, 1 corrected, 2 code corrupt, 3 uncorrectable |
| err_byte | output | 9 | Byte index of the flipped bit |
| err_bit | output | 3 | Bit index within that byte |
| fix_rd_en | output | 1 | Sector buffer read strobe |
| fix_wr_en | output | 1 | Sector buffer write strobe |
| fix_addr | output | 9 | Sector buffer byte address |
| fix_wr_data | output | 8 | Repaired byte to write |
| fix_rd_data | input | 8 | Byte returned by the buffer one cycle after a read |

## Verification
The assertions check on every cycle the properties that hold whatever the codes are:
- the fixed latency of `done`;
- the zeroed indices outside the corrected outcome;
- the clean result for equal codes and for the erased pattern;
- the silence of the buffer port after a corrupt-code result;
- the read-to-write spacing and the stable address of the repair.

Only the bench scenarios can show that the weight rules classify the reordered difference correctly, or that the repaired byte in the modelled buffer ends up with exactly the reported bit flipped. They also show that back-to-back strobes keep their results apart. Those scenarios use true single-error patterns, single code-bit flips, erased sectors and random differences.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN   = 2'd0,
    ST_FIXED   = 2'd1,
    ST_BADCODE = 2'd2,
    ST_MULTI   = 2'd3
  } chk_status_t;

  localparam int CODE_W   = 24;
  localparam int WORD_W   = 32;
  localparam int OCTET_W  = 8;
  localparam int NIBBLE_W = 4;

endpackage

// File: rtl/ecc_code_repack.sv
module ecc_code_repack
  import ecc_chk_pkg::*;
(
  input  logic [CODE_W-1:0] code_in,
  output logic [WORD_W-1:0] word_out
);

  localparam int LO_OCT_POS  = 0;
  localparam int HI_OCT_POS  = 16;
  localparam int LO_NIB_POS  = 8;
  localparam int HI_NIB_POS  = 24;

  logic [OCTET_W-1:0]  oct0;
  logic [OCTET_W-1:0]  oct1;
  logic [OCTET_W-1:0]  oct2;

  always_comb begin
    oct0 = code_in[0*OCTET_W +: OCTET_W];
    oct1 = code_in[1*OCTET_W +: OCTET_W];
    oct2 = code_in[2*OCTET_W +: OCTET_W];
    word_out = '0;
    word_out[LO_OCT_POS +: OCTET_W]  = oct0;
    word_out[HI_OCT_POS +: OCTET_W]  = oct1;
    word_out[LO_NIB_POS +: NIBBLE_W] = oct2[NIBBLE_W-1:0];
    word_out[HI_NIB_POS +: NIBBLE_W] = oct2[OCTET_W-1:NIBBLE_W];
  end

endmodule

// File: rtl/ecc_weight_classify.sv
module ecc_weight_classify
  import ecc_chk_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int DATA_W       = 8,
  parameter int FIX_WEIGHT   = 12,
  parameter logic [WORD_W-1:0] ERASED_WORD = 32'h0FFF_0FFF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [WORD_W-1:0]       stored_w,
  input  logic [WORD_W-1:0]       calc_w,
  output logic                    out_valid,
  output chk_status_t             out_status,
  output logic [$clog2(SECTOR_BYTES)-1:0] out_byte,
  output logic [$clog2(DATA_W)-1:0]       out_bit
);

  localparam int BYTE_IDX_W = $clog2(SECTOR_BYTES);
  localparam int BIT_IDX_W  = $clog2(DATA_W);
  localparam int CNT_W      = $clog2(WORD_W + 1);
  localparam int POS_BASE   = WORD_W / 2;

  function automatic logic [CNT_W-1:0] weight_of(input logic [WORD_W-1:0] w);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < WORD_W; i++) begin
      acc = acc + {{(CNT_W-1){1'b0}}, w[i]};
    end
    return acc;
  endfunction

  // stage 1: difference, its weight and the erased-sector flag
  logic                 s1_valid;
  logic [WORD_W-1:0]    s1_diff;
  logic [CNT_W-1:0]     s1_weight;
  logic                 s1_erased;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_diff   <= '0;
      s1_weight <= '0;
      s1_erased <= 1'b0;
    end else begin
      s1_valid  <= in_valid;
      s1_diff   <= stored_w ^ calc_w;
      s1_weight <= weight_of(stored_w ^ calc_w);
      s1_erased <= (stored_w == ERASED_WORD) && (calc_w == '0);
    end
  end

  // stage 2: outcome and error position
  chk_status_t              nx_status;
  logic [BYTE_IDX_W-1:0]    nx_byte;
  logic [BIT_IDX_W-1:0]     nx_bit;

  always_comb begin
    nx_byte = '0;
    nx_bit  = '0;
    if (s1_diff == '0) begin
      nx_status = ST_CLEAN;
    end else if (s1_erased) begin
      nx_status = ST_CLEAN;
    end else if (s1_weight == CNT_W'(FIX_WEIGHT)) begin
      nx_status = ST_FIXED;
      nx_bit    = s1_diff[POS_BASE +: BIT_IDX_W];
      nx_byte   = s1_diff[POS_BASE + BIT_IDX_W +: BYTE_IDX_W];
    end else if (s1_weight == CNT_W'(1)) begin
      nx_status = ST_BADCODE;
    end else begin
      nx_status = ST_MULTI;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_status <= ST_CLEAN;
      out_byte   <= '0;
      out_bit    <= '0;
    end else if (s1_valid) begin
      out_valid  <= 1'b1;
      out_status <= nx_status;
      out_byte   <= nx_byte;
      out_bit    <= nx_bit;
    end else begin
      out_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/ecc_bit_fixer.sv
module ecc_bit_fixer #(
  parameter int SECTOR_BYTES = 512,
  parameter int DATA_W       = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            req,
  input  logic [$clog2(SECTOR_BYTES)-1:0] req_byte,
  input  logic [$clog2(DATA_W)-1:0]       req_bit,
  input  logic [DATA_W-1:0]               rd_data,
  output logic                            rd_en,
  output logic                            wr_en,
  output logic [$clog2(SECTOR_BYTES)-1:0] addr,
  output logic [DATA_W-1:0]               wr_data
);

  localparam int BIT_IDX_W = $clog2(DATA_W);

  logic                 wait_rd;
  logic [BIT_IDX_W-1:0] bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en   <= 1'b0;
      wait_rd <= 1'b0;
      wr_en   <= 1'b0;
      addr    <= '0;
      bit_q   <= '0;
      wr_data <= '0;
    end else begin
      rd_en   <= req;
      wait_rd <= rd_en;
      wr_en   <= wait_rd;
      if (req) begin
        addr  <= req_byte;
        bit_q <= req_bit;
      end
      if (wait_rd) begin
        wr_data <= rd_data ^ (DATA_W'(1) << bit_q);
      end
    end
  end

endmodule

// File: rtl/ecc_sector_checker.sv
module ecc_sector_checker
  import ecc_chk_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int DATA_W       = 8,
  parameter bit FIX_EN       = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            code_valid,
  input  logic [CODE_W-1:0]               stored_code,
  input  logic [CODE_W-1:0]               calc_code,
  output logic                            done,
  output logic [1:0]                      status,
  output logic [$clog2(SECTOR_BYTES)-1:0] err_byte,
  output logic [$clog2(DATA_W)-1:0]       err_bit,
  output logic                            fix_rd_en,
  output logic                            fix_wr_en,
  output logic [$clog2(SECTOR_BYTES)-1:0] fix_addr,
  output logic [DATA_W-1:0]               fix_wr_data,
  input  logic [DATA_W-1:0]               fix_rd_data
);

  localparam int BYTE_IDX_W = $clog2(SECTOR_BYTES);
  localparam int BIT_IDX_W  = $clog2(DATA_W);

  logic [WORD_W-1:0]     stored_word;
  logic [WORD_W-1:0]     calc_word;
  chk_status_t           res_status;
  logic [BYTE_IDX_W-1:0] res_byte;
  logic [BIT_IDX_W-1:0]  res_bit;
  logic                  res_valid;

  ecc_code_repack u_rp_stored (.code_in(stored_code), .word_out(stored_word));
  ecc_code_repack u_rp_calc   (.code_in(calc_code),   .word_out(calc_word));

  ecc_weight_classify #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .DATA_W       (DATA_W)
  ) u_classify (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (code_valid),
    .stored_w   (stored_word),
    .calc_w     (calc_word),
    .out_valid  (res_valid),
    .out_status (res_status),
    .out_byte   (res_byte),
    .out_bit    (res_bit)
  );

  assign done     = res_valid;
  assign status   = res_status;
  assign err_byte = res_byte;
  assign err_bit  = res_bit;

  generate
    if (FIX_EN) begin : g_fix
      ecc_bit_fixer #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .DATA_W       (DATA_W)
      ) u_fixer (
        .clk      (clk),
        .rst      (rst),
        .req      (res_valid && (res_status == ST_FIXED)),
        .req_byte (res_byte),
        .req_bit  (res_bit),
        .rd_data  (fix_rd_data),
        .rd_en    (fix_rd_en),
        .wr_en    (fix_wr_en),
        .addr     (fix_addr),
        .wr_data  (fix_wr_data)
      );
    end else begin : g_nofix
      assign fix_rd_en   = 1'b0;
      assign fix_wr_en   = 1'b0;
      assign fix_addr    = '0;
      assign fix_wr_data = '0;
    end
  endgenerate

endmodule

// File: rtl/ecc_sector_checker_sva.sv
module ecc_sector_checker_sva (
  input logic        clk,
  input logic        rst,
  input logic        code_valid,
  input logic [23:0] stored_code,
  input logic [23:0] calc_code,
  input logic        done,
  input logic [1:0]  status,
  input logic [8:0]  err_byte,
  input logic [2:0]  err_bit,
  input logic        fix_rd_en,
  input logic        fix_wr_en,
  input logic [8:0]  fix_addr
);

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    code_valid |=> ##1 done);

  assert_idx_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (done && status != 2'd1) |-> (err_byte == 9'd0 && err_bit == 3'd0));

  assert_equal_clean_R2: assert property (@(posedge clk) disable iff (rst)
    (code_valid && stored_code == calc_code) |=> ##1 (status == 2'd0));

  assert_erased_clean_R5: assert property (@(posedge clk) disable iff (rst)
    (code_valid && stored_code == 24'hFFFFFF && calc_code == 24'h0)
      |=> ##1 (status == 2'd0));

  assert_corrupt_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (done && status == 2'd2) |=> !fix_rd_en);

  assert_write_follows_R9: assert property (@(posedge clk) disable iff (rst)
    fix_rd_en |=> ##1 (fix_wr_en && $stable(fix_addr)));

  assert_read_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(fix_rd_en) |-> $past(done && status == 2'd1));

endmodule

bind ecc_sector_checker ecc_sector_checker_sva u_sva (
  .clk         (clk),
  .rst         (rst),
  .code_valid  (code_valid),
  .stored_code (stored_code),
  .calc_code   (calc_code),
  .done        (done),
  .status      (status),
  .err_byte    (err_byte),
  .err_bit     (err_bit),
  .fix_rd_en   (fix_rd_en),
  .fix_wr_en   (fix_wr_en),
  .fix_addr    (fix_addr)
);

// File: tb/ecc_sector_checker_tb.sv
module ecc_sector_checker_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        code_valid = 1'b0;
  logic [23:0] stored_code = '0;
  logic [23:0] calc_code = '0;
  logic        done;
  logic [1:0]  status;
  logic [8:0]  err_byte;
  logic [2:0]  err_bit;
  logic        fix_rd_en;
  logic        fix_wr_en;
  logic [8:0]  fix_addr;
  logic [7:0]  fix_wr_data;
  logic [7:0]  fix_rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  int n_writes = 0;
  logic [7:0] mem   [512];
  logic [7:0] shadow[512];

  always #2 clk = ~clk;

  ecc_sector_checker u_dut (
    .clk(clk), .rst(rst), .code_valid(code_valid),
    .stored_code(stored_code), .calc_code(calc_code),
    .done(done), .status(status), .err_byte(err_byte), .err_bit(err_bit),
    .fix_rd_en(fix_rd_en), .fix_wr_en(fix_wr_en), .fix_addr(fix_addr),
    .fix_wr_data(fix_wr_data), .fix_rd_data(fix_rd_data)
  );

  // sector buffer model, one-cycle read latency
  always @(posedge clk) begin
    if (fix_rd_en) fix_rd_data <= mem[fix_addr];
    if (fix_wr_en) begin
      mem[fix_addr] <= fix_wr_data;
      n_writes <= n_writes + 1;
    end
  end

  function automatic logic [31:0] repack(input logic [23:0] c);
    return {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
  endfunction

  function automatic logic [23:0] unpack(input logic [31:0] w);
    return {w[27:24], w[11:8], w[23:16], w[7:0]};
  endfunction

  function automatic logic [1:0] exp_status(input logic [23:0] s, input logic [23:0] c);
    logic [31:0] x;
    x = repack(s) ^ repack(c);
    if (x == 0) return 2'd0;
    if (repack(s) == 32'h0FFF0FFF && c == 0) return 2'd0;
    if ($countones(x) == 12) return 2'd1;
    if ($countones(x) == 1) return 2'd2;
    return 2'd3;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [23:0] s, input logic [23:0] c);
    logic [31:0] x;
    logic [1:0]  es;
    int          wr0;
    x  = repack(s) ^ repack(c);
    es = exp_status(s, c);
    wr0 = n_writes;
    @(negedge clk);
    stored_code = s; calc_code = c; code_valid = 1'b1;
    @(negedge clk);
    code_valid = 1'b0;
    check("R7 done low one cycle after strobe", done, 0);
    @(negedge clk);
    check("R7 done", done, 1);
    check("R2/R3/R4/R5/R6 status", status, es);
    if (es == 2'd1) begin
      check("R3 byte index", err_byte, x[27:19]);
      check("R3 bit index", err_bit, x[18:16]);
      shadow[x[27:19]] = shadow[x[27:19]] ^ (8'd1 << x[18:16]);
    end else begin
      check("R8 indices zero", {err_byte, err_bit}, 0);
    end
    @(negedge clk);
    check("R7 done single pulse", done, 0);
    check("R9 read strobe", fix_rd_en, (es == 2'd1));
    repeat (3) @(negedge clk);
    if (es == 2'd1) begin
      check("R9 repaired byte", mem[x[27:19]], shadow[x[27:19]]);
      check("R9 one write", n_writes - wr0, 1);
    end else begin
      check("R4 no buffer write", n_writes - wr0, 0);
    end
  endtask

  initial begin
    int seed_val;
    logic [23:0] s;
    logic [23:0] d;
    logic [11:0] p;
    seed_val = $urandom(32'd1234);
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'(i * 37 + 5);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check("R10 done reset", done, 0);
    check("R10 status reset", status, 0);
    check("R10 fix strobes reset", {fix_rd_en, fix_wr_en}, 0);
    rst = 1'b0;
    @(negedge clk);

    // directed corners
    run_case(24'h123456, 24'h123456);                      // R2
    run_case(24'hFFFFFF, 24'h000000);                      // R5 erased
    run_case(24'hA5A5A5, 24'hA5A5A5 ^ 24'h800000);         // R4/R1 nibble bit
    run_case(24'h000000, unpack({4'h0, 12'hFFF, 4'h0, 12'h000})); // R3 byte 511 bit 7
    run_case(24'h3C3C3C, 24'h3C3C3C ^ unpack({4'h0, 12'h000, 4'h0, 12'hFFF})); // R3 byte 0
    run_case(24'h000000, 24'h000003);                      // R6 weight 2
    run_case(24'hFFFFFF, 24'h000001);                      // R6 near erased
    check("R1 repack layout", repack(24'hABCDEF), 32'h0ACD0BEF);

    // back-to-back strobes R11
    @(negedge clk);
    stored_code = 24'h111111; calc_code = 24'h111111; code_valid = 1'b1;
    @(negedge clk);
    stored_code = 24'h111111; calc_code = 24'h111110;
    @(negedge clk);
    code_valid = 1'b0;
    check("R11 first result", {done, status}, {1'b1, 2'd0});
    @(negedge clk);
    check("R11 second result", {done, status}, {1'b1, 2'd2});
    @(negedge clk);
    check("R11 pipeline drains", done, 0);

    // constrained random mix
    for (int k = 0; k < 300; k++) begin
      int kind;
      s = 24'($urandom);
      kind = int'($urandom % 5);
      case (kind)
        0: d = 24'h0;
        1: d = 24'h1 << ($urandom % 24);
        2: begin p = 12'($urandom); d = unpack({4'h0, p, 4'h0, ~p}); end
        3: d = 24'($urandom);
        default: begin s = 24'hFFFFFF; d = 24'hFFFFFF; end
      endcase
      run_case(s, s ^ d);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule